// File: doc/BRIEF.md
# Chip-Select Address Region Decoder

This block takes a system address and works out which of eight external memory banks it belongs to. Each bank holds a small mapping record: an enable, a 6-bit region base and a 4-bit size mask. The size mask gives one of four region sizes: 16, 32, 64 or 128 MB. The decoder checks every record for legality on its own. An access then selects the lowest-numbered bank whose region holds the address. The result comes out as a one-hot chip-select vector, together with the selected region's base and size.

Mapping records are loaded through a narrow write port, one bank per write. They take effect for requests presented from the next clock on. A request is a one-cycle strobe with an address. The decoder returns its verdict one clock later as a one-cycle response pulse. The verdict is a hit or a miss, and an overlap flag that is raised when more than one bank claimed the address. A per-bank flag shows any enabled bank whose record is illegal, so that mis-programming is visible without issuing traffic.

Top module: `cs_region_decoder`

## Requirements
- R1: After reset, only bank 0 is enabled, with base 0 and mask 0xF. Banks 1 to 7 are disabled with base 0 and mask 0xF. The response valid, chip-select vector and map-error vector are all zero.
- R2: A write with `cfg_wr` high stores `cfg_en`, `cfg_base` and `cfg_mask` into bank `cfg_bank`. The new record governs requests presented from the following clock on, and the other banks are left untouched.
- R3: A bank whose mask is not 0x8, 0xC, 0xE or 0xF is illegal and never selects.
- R4: A bank whose base bits [3:0], ANDed with the inverted mask, are not zero is illegal and never selects.
- R5: A legal, enabled bank claims an address when address bits [29:24] ANDed with {2'b00, mask} equal the base ANDed with {2'b00, mask}. Address bits [31:30] and [23:0] do not take part.
- R6: One clock after a cycle with `req_valid` high, `rsp_valid` is high for exactly one cycle with the decode of that address. In cycles without a request, the decode outputs hold their values.
- R7: When several banks claim an address, the lowest-numbered one is selected and `cs_overlap` is set. `cs_overlap` is clear when exactly one bank claims it.
- R8: When no bank claims an address, `cs_miss` is set, `cs_hit` is clear, and `cs_sel`, `rgn_base` and `rgn_size` are zero.
- R9: On a hit, `rgn_base` equals the selected bank's base shifted left by 24. `rgn_size` is 0x08000000, 0x04000000, 0x02000000 or 0x01000000 for masks 0x8, 0xC, 0xE or 0xF respectively.
- R10: `map_err[i]` is high exactly when bank i is enabled and illegal. A disabled bank never selects and never raises `map_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for one bank record |
| cfg_bank | input | 3 | Bank index of the write |
| cfg_en | input | 1 | Enable bit of the written record |
| cfg_base | input | 6 | Region base field of the written record |
| cfg_mask | input | 4 | Size mask field of the written record |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| cs_sel | output | 8 | One-hot chip select of the winning bank |
| cs_hit | output | 1 | Some bank claimed the address |
| cs_miss | output | 1 | No bank claimed the address |
| cs_overlap | output | 1 | More than one bank claimed the address |
| rgn_base | output | 32 | Base address of the selected region |
| rgn_size | output | 32 | Size in bytes of the selected region |
| map_err | output | 8 | Per-bank flag: enabled with an illegal record |

## Verification
The response-side assertions assume that a bank record is not rewritten in the same cycle as a request. If it were, the verdict would reflect the old record while the map-error flags already show the new one. The stimulus keeps record writes and requests in separate cycles: each write and each request takes its own cycle, followed by an idle cycle. Random addresses are mostly built to fall inside a chosen bank's region, with free bits set randomly, so that aliasing, overlap and miss cases all occur under the fixed seed.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

  localparam int BASE_W = 6;
  localparam int MASK_W = 4;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic              en;
    logic [BASE_W-1:0] base;
  } cs_rec_t;

  // Only contiguous-from-top mask patterns give a legal region size.
  function automatic logic mask_ok(input logic [MASK_W-1:0] m);
    logic ok;
    ok = 1'b0;
    for (int k = 0; k < MASK_W; k++) begin
      if (m == MASK_W'(~((1 << (MASK_W - 1 - k)) - 1))) ok = 1'b1;
    end
    return ok;
  endfunction

endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cs_bank_slot.sv
module cs_bank_slot
  import cs_dec_pkg::*;
#(
  parameter int      ADDR_W     = 32,
  parameter int      REGION_LSB = 24,
  parameter cs_rec_t RST_REC    = '{mask: 4'hF, en: 1'b0, base: 6'd0}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  cs_rec_t           wr_rec,
  input  logic [ADDR_W-1:0] addr,
  output logic              claim,
  output logic              bad_map,
  output logic [ADDR_W-1:0] rgn_base,
  output logic [ADDR_W-1:0] rgn_size
);
  localparam int BASE_PAD = ADDR_W - REGION_LSB - BASE_W;
  localparam int SPAN_W   = REGION_LSB + MASK_W;
  localparam logic [ADDR_W-1:0] SPAN_LIM = ADDR_W'((64'd1 << SPAN_W) - 1);

  cs_rec_t rec_q, rec_d;
  logic    legal;
  logic [BASE_W-1:0] wide_mask;

  // next-state
  always_comb begin
    rec_d = rec_q;
    if (wr_en) rec_d = wr_rec;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec_q <= RST_REC;
    else        rec_q <= rec_d;
  end

  assign wide_mask = {{(BASE_W-MASK_W){1'b0}}, rec_q.mask};

  always_comb begin
    legal   = mask_ok(rec_q.mask) && ((rec_q.base[MASK_W-1:0] & ~rec_q.mask) == '0);
    bad_map = rec_q.en && !legal;
    claim   = rec_q.en && legal &&
              ((addr[REGION_LSB +: BASE_W] & wide_mask) == (rec_q.base & wide_mask));
    rgn_base = {{BASE_PAD{1'b0}}, rec_q.base, {REGION_LSB{1'b0}}};
    rgn_size = (SPAN_LIM & ~({{(ADDR_W-MASK_W){1'b0}}, rec_q.mask} << REGION_LSB)) + 1'b1;
  end

  // a written record is what the next cycle decodes with (R2)
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rec_q == $past(wr_rec)));

  // an illegal record never claims (R3, R4)
  p_bad_never_claims_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bad_map && claim));
endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any,
  output logic         multi
);
  always_comb begin
    grant = req & (~req + 1'b1);
    any   = |req;
    multi = |(req & ~grant);
  end

  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));

  p_multi_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    multi == ($countones(req) > 1));
endmodule

// File: rtl/cs_region_decoder.sv
module cs_region_decoder
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 24,
  localparam int SEL_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [SEL_W-1:0]     cfg_bank,
  input  logic                 cfg_en,
  input  logic [BASE_W-1:0]    cfg_base,
  input  logic [MASK_W-1:0]    cfg_mask,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 rsp_valid,
  output logic [NUM_BANKS-1:0] cs_sel,
  output logic                 cs_hit,
  output logic                 cs_miss,
  output logic                 cs_overlap,
  output logic [ADDR_W-1:0]    rgn_base,
  output logic [ADDR_W-1:0]    rgn_size,
  output logic [NUM_BANKS-1:0] map_err
);
  logic    rst_i_n;
  cs_rec_t wr_rec;
  logic [NUM_BANKS-1:0] claims, grant;
  logic                 any_claim, many_claim;
  logic [ADDR_W-1:0]    bank_base [NUM_BANKS];
  logic [ADDR_W-1:0]    bank_size [NUM_BANKS];
  logic [ADDR_W-1:0]    win_base, win_size;

  logic                 rsp_q;
  logic [NUM_BANKS-1:0] sel_q,  sel_d;
  logic                 hit_q,  hit_d;
  logic                 ovl_q,  ovl_d;
  logic [ADDR_W-1:0]    base_q, base_d;
  logic [ADDR_W-1:0]    size_q, size_d;

  cs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign wr_rec = '{mask: cfg_mask, en: cfg_en, base: cfg_base};

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam cs_rec_t RST_G = '{mask: {MASK_W{1'b1}}, en: (g == 0), base: '0};
    cs_bank_slot #(
      .ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB), .RST_REC(RST_G)
    ) u_slot (
      .clk(clk), .rst_n(rst_i_n),
      .wr_en(cfg_wr && (cfg_bank == SEL_W'(g))),
      .wr_rec(wr_rec),
      .addr(req_addr),
      .claim(claims[g]),
      .bad_map(map_err[g]),
      .rgn_base(bank_base[g]),
      .rgn_size(bank_size[g])
    );
  end

  cs_prio_pick #(.N(NUM_BANKS)) u_pick (
    .clk(clk), .rst_n(rst_i_n),
    .req(claims), .grant(grant), .any(any_claim), .multi(many_claim)
  );

  always_comb begin
    win_base = '0;
    win_size = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (grant[i]) begin
        win_base = win_base | bank_base[i];
        win_size = win_size | bank_size[i];
      end
    end
  end

  // next-state: outputs load only on a request
  always_comb begin
    sel_d  = sel_q;
    hit_d  = hit_q;
    ovl_d  = ovl_q;
    base_d = base_q;
    size_d = size_q;
    if (req_valid) begin
      sel_d  = grant;
      hit_d  = any_claim;
      ovl_d  = many_claim;
      base_d = win_base;
      size_d = win_size;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_q  <= 1'b0;
      sel_q  <= '0;
      hit_q  <= 1'b0;
      ovl_q  <= 1'b0;
      base_q <= '0;
      size_q <= '0;
    end else begin
      rsp_q  <= req_valid;
      sel_q  <= sel_d;
      hit_q  <= hit_d;
      ovl_q  <= ovl_d;
      base_q <= base_d;
      size_q <= size_d;
    end
  end

  assign rsp_valid  = rsp_q;
  assign cs_sel     = sel_q;
  assign cs_hit     = hit_q;
  assign cs_miss    = rsp_q && !hit_q;
  assign cs_overlap = ovl_q;
  assign rgn_base   = base_q;
  assign rgn_size   = size_q;

  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid |=> rsp_valid);

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    !req_valid |=> (!rsp_valid && $stable(cs_sel) && $stable(rgn_base)));

  p_sel_matches_hit_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid |-> ($onehot0(cs_sel) && (cs_hit == (cs_sel != '0)) && (cs_hit != cs_miss)));

  p_size_aligned_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rsp_valid && cs_hit) |-> ($onehot(rgn_size) && ((rgn_base & (rgn_size - 1'b1)) == '0)));

  p_no_sel_on_err_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid |-> ((cs_sel & $past(map_err)) == '0));

  p_overlap_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    cs_overlap |-> cs_hit);
endmodule

// File: tb/tb_cs_region_decoder.sv
module tb_cs_region_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [2:0]  cfg_bank;
  logic        cfg_en;
  logic [5:0]  cfg_base;
  logic [3:0]  cfg_mask;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        rsp_valid, cs_hit, cs_miss, cs_overlap;
  logic [7:0]  cs_sel, map_err;
  logic [31:0] rgn_base, rgn_size;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic       m_en   [8];
  logic [5:0] m_base [8];
  logic [3:0] m_mask [8];

  always #2.5 clk = ~clk;

  cs_region_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_bank(cfg_bank),
    .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .cs_sel(cs_sel), .cs_hit(cs_hit), .cs_miss(cs_miss),
    .cs_overlap(cs_overlap), .rgn_base(rgn_base), .rgn_size(rgn_size),
    .map_err(map_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic legal_m(input int i);
    logic mok;
    mok = (m_mask[i] == 4'h8) || (m_mask[i] == 4'hC) ||
          (m_mask[i] == 4'hE) || (m_mask[i] == 4'hF);
    return mok && ((m_base[i][3:0] & ~m_mask[i]) == 4'h0);
  endfunction

  function automatic logic [7:0] exp_err();
    logic [7:0] e;
    for (int i = 0; i < 8; i++) e[i] = m_en[i] && !legal_m(i);
    return e;
  endfunction

  function automatic logic [31:0] size_of(input logic [3:0] m);
    case (m)
      4'h8: return 32'h0800_0000;
      4'hC: return 32'h0400_0000;
      4'hE: return 32'h0200_0000;
      default: return 32'h0100_0000;
    endcase
  endfunction

  task automatic wr_bank(input int b, input logic en, input logic [5:0] base, input logic [3:0] mask);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_bank = 3'(b); cfg_en = en; cfg_base = base; cfg_mask = mask;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_en[b] = en; m_base[b] = base; m_mask[b] = mask;
  endtask

  task automatic do_req(input logic [31:0] a, input string tag);
    logic [7:0] claims, e_sel;
    int n, w;
    logic [7:0] prev_sel;
    claims = '0; n = 0; w = -1;
    for (int i = 0; i < 8; i++) begin
      if (m_en[i] && legal_m(i) && ((a[27:24] & m_mask[i]) == (m_base[i][3:0] & m_mask[i]))) begin
        claims[i] = 1'b1; n++;
        if (w < 0) w = i;
      end
    end
    e_sel = (w < 0) ? 8'h00 : 8'(1 << w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_addr = $urandom;
    chk({tag, " R6 rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " R7 cs_sel"}, 32'(cs_sel), 32'(e_sel));
    chk({tag, " R7 overlap"}, 32'(cs_overlap), 32'(n > 1));
    chk({tag, " R8 hit/miss"}, {30'd0, cs_hit, cs_miss}, (n > 0) ? 32'd2 : 32'd1);
    chk({tag, " R9 rgn_base"}, rgn_base, (w < 0) ? 32'd0 : {2'b00, m_base[w], 24'd0});
    chk({tag, " R9 rgn_size"}, rgn_size, (w < 0) ? 32'd0 : size_of(m_mask[w]));
    chk({tag, " R10 map_err"}, 32'(map_err), 32'(exp_err()));
    prev_sel = cs_sel;
    @(negedge clk);
    chk({tag, " R6 idle hold"}, {23'd0, rsp_valid, cs_sel}, {24'd0, prev_sel});
  endtask

  function automatic logic [31:0] addr_in(input int b);
    logic [31:0] a;
    logic [3:0] r;
    a = $urandom;
    r = 4'($urandom);
    a[27:24] = (r & ~m_mask[b]) | (m_base[b][3:0] & m_mask[b]);
    return a;
  endfunction

  initial begin
    void'($urandom(32'h1D2C_3B4A));
    rst_n = 1'b0; cfg_wr = 0; cfg_bank = 0; cfg_en = 0; cfg_base = 0; cfg_mask = 0;
    req_valid = 0; req_addr = 0;
    for (int i = 0; i < 8; i++) begin
      m_en[i] = (i == 0); m_base[i] = 6'd0; m_mask[i] = 4'hF;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 cs_sel", 32'(cs_sel), 32'd0);
    chk("R1 map_err", 32'(map_err), 32'd0);
    do_req(32'h0012_3456, "R1 bank0 hit");
    do_req(32'h0500_0000, "R1 bank0 miss");
    do_req(32'hF0FF_FFFF, "R5 alias upper bits");
    do_req(32'h3000_0000, "R5 alias base bits 29:28");

    // R3 illegal mask, R10 error flag
    wr_bank(1, 1'b1, 6'h05, 4'h5);
    do_req(32'h0500_0000, "R3 illegal mask");
    wr_bank(1, 1'b0, 6'h05, 4'h5);
    do_req(32'h0500_0000, "R10 disabled illegal");
    // R4 misaligned base
    wr_bank(2, 1'b1, 6'h03, 4'hE);
    do_req(32'h0300_0000, "R4 misaligned base");
    wr_bank(2, 1'b1, 6'h02, 4'hE);
    do_req(32'h0300_0000, "R4 aligned base 32MB");
    // R2 overwrite and R7 overlap
    wr_bank(3, 1'b1, 6'h08, 4'h8);
    wr_bank(5, 1'b1, 6'h0A, 4'hE);
    do_req(32'h0A00_0010, "R7 overlap 3 over 5");
    wr_bank(3, 1'b0, 6'h08, 4'h8);
    do_req(32'h0A00_0010, "R2 rewrite drops bank3");
    wr_bank(4, 1'b1, 6'h04, 4'hC);
    do_req(32'h0700_0000, "R9 64MB region");
    wr_bank(0, 1'b0, 6'h00, 4'hF);
    do_req(32'h0000_0000, "R8 miss");

    // random mix
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 4) == 0) begin
        int b;
        logic [3:0] mk;
        logic [5:0] bs;
        b = $urandom % 8;
        case ($urandom % 6)
          0: mk = 4'h8; 1: mk = 4'hC; 2: mk = 4'hE; 3: mk = 4'hF;
          default: mk = 4'($urandom);
        endcase
        bs = 6'($urandom);
        if (($urandom % 4) != 0) bs[3:0] = bs[3:0] & mk;
        wr_bank(b, ($urandom % 4) != 0, bs, mk);
      end
      if (($urandom % 5) == 0) do_req($urandom, "R5 random addr");
      else do_req(addr_in($urandom % 8), "R5 targeted addr");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule